// File: doc/BRIEF.md
# Gain-Scheduled PID Duty Regulator

This block closes the voltage loop of a switching power converter in the digital domain. Once per switching period a sample strobe delivers two converter measurements. One is a 10-bit code for the scaled output-voltage deviation. The other is a 12-bit code for the input supply voltage. The block turns the output code into a signed control error and runs a position-form PID law on that error. It returns a saturated 9-bit duty word one clock later. A PWM modulator with a gain of 1/512 is expected to consume that word.

The proportional gain is not fixed. It is chosen from three input-voltage bands, and it is lowered as the supply rises so the loop does not oscillate at high line. During a deep output sag the gain is raised by one more step to speed up recovery. The integral gain of one half is an arithmetic right shift. The integrator is clamped to the duty range, so it cannot wind up. The derivative term uses the difference between this error and the previous one.

Top module: `pid_duty_reg`

## Requirements
- R1: While `rst_n` is low, `duty` is 0 and `duty_vld` is 0. The integrator and the stored previous error are both cleared to 0.
- R2: The control error is 512 minus `err_code`, a signed value from +512 (code 0) down to -511 (code 1023).
- R3: `duty_vld` is high for exactly the one clock that follows a clock with `sample_vld` high, and `duty` changes only in that cycle.
- R4: On each sample the integrator becomes the old integrator plus the error shifted right by one bit (arithmetic, so -1 gives -1). The sum is clamped to 0..511, and the clamped value feeds the output of that same sample.
- R5: The derivative term is 4 times (error minus previous error). The previous error is the one of the last accepted sample and is 0 after reset.
- R6: The scheduled proportional gain comes from `vin_code` at 5 mV per LSB: codes below 2700 give 6, codes 2700 to 3299 give 5, and codes 3300 and above give 4.
- R7: When the error is 64 or more (output at or below 128 mV under the set point), the proportional gain is the scheduled value plus one. When the error is 63 or less, the scheduled value is used.
- R8: The duty word is kp·error + integrator + derivative term, saturated to the range 0..511.
- R9: `err_code` and `vin_code` have no effect while `sample_vld` is low: the output and the next computed duty depend only on strobed samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | One-clock strobe marking a new measurement pair |
| err_code | input | 10 | Output-deviation ADC code, 512 at the set point |
| vin_code | input | 12 | Input-voltage ADC code, 5 mV per LSB |
| duty_vld | output | 1 | High for one clock when `duty` is new |
| duty | output | 9 | Saturated duty word, gain 1/512 |

## Verification
A corrupted integrator has no direct port of its own. It shows as a constant offset in `duty` on the very next strobe, and the offset builds up over later strobes until saturation hides it. The bench therefore checks every strobe against a running model rather than only at the end. A stale previous error shows up at once as a wrong derivative step on the next sample. A wrong gain band or boost edge shows as a wrong duty value on the same strobe as the boundary code. The directed cases place the codes exactly on those edges.

// File: rtl/pid_duty_reg.sv
module pid_duty_reg #(
  parameter int ADC_W      = 10,
  parameter int VIN_W      = 12,
  parameter int DUTY_W     = 9,
  parameter int REF_CODE   = 512,
  parameter int UV_ERR     = 64,
  parameter int KP_LOW     = 6,
  parameter int KP_MID     = 5,
  parameter int KP_HIGH    = 4,
  parameter int KD         = 4,
  parameter int VIN_MV_LSB = 5,
  parameter int BAND1_MV   = 13500,
  parameter int BAND2_MV   = 16500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_vld,
  input  logic [ADC_W-1:0]  err_code,
  input  logic [VIN_W-1:0]  vin_code,
  output logic              duty_vld,
  output logic [DUTY_W-1:0] duty
);

  localparam int ERR_W = ADC_W + 1;
  localparam int ACC_W = ADC_W + 8;
  localparam int TH1   = BAND1_MV / VIN_MV_LSB;
  localparam int TH2   = BAND2_MV / VIN_MV_LSB;
  localparam int DMAX  = (1 << DUTY_W) - 1;
  localparam logic signed [ACC_W-1:0] DMAX_S = ACC_W'(DMAX);
  localparam logic signed [ACC_W-1:0] KD_S   = ACC_W'(KD);
  localparam logic signed [ERR_W-1:0] UV_S   = ERR_W'(UV_ERR);

  logic signed [ERR_W-1:0]  err, prev_q;
  logic [DUTY_W-1:0]        integ_q;
  logic [3:0]               kp_sched, kp_eff;
  logic signed [ACC_W-1:0]  err_x, prev_x, kp_x, integ_sum, integ_nx;
  logic signed [ACC_W-1:0]  p_term, d_term, u_sum;
  logic [DUTY_W-1:0]        duty_nx;

  assign err = $signed(ERR_W'(REF_CODE)) - $signed({1'b0, err_code});

  assign kp_sched = (vin_code < VIN_W'(TH1)) ? 4'(KP_LOW) :
                    (vin_code < VIN_W'(TH2)) ? 4'(KP_MID) : 4'(KP_HIGH);
  assign kp_eff   = (err >= UV_S) ? kp_sched + 4'd1 : kp_sched;

  assign err_x  = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
  assign prev_x = {{(ACC_W-ERR_W){prev_q[ERR_W-1]}}, prev_q};
  assign kp_x   = ACC_W'(kp_eff);

  assign integ_sum = $signed(ACC_W'(integ_q)) + (err_x >>> 1);
  assign integ_nx  = (integ_sum < 0) ? '0 : (integ_sum > DMAX_S) ? DMAX_S : integ_sum;

  assign p_term = kp_x * err_x;
  assign d_term = KD_S * (err_x - prev_x);
  assign u_sum  = p_term + integ_nx + d_term;
  assign duty_nx = (u_sum < 0) ? '0 : (u_sum > DMAX_S) ? DUTY_W'(DMAX) : DUTY_W'(u_sum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      integ_q  <= '0;
      duty     <= '0;
      duty_vld <= 1'b0;
    end else begin
      duty_vld <= sample_vld;
      if (sample_vld) begin
        prev_q  <= err;
        integ_q <= DUTY_W'(integ_nx);
        duty    <= duty_nx;
      end
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> duty_vld);  // R3
  AST_NO_STRAY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> !duty_vld);  // R3
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(duty));  // R9
  AST_INTEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(integ_q));  // R4
  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> prev_q == $past(err));  // R5
  AST_KP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> (kp_eff >= 4'(KP_HIGH)) && (kp_eff <= 4'(KP_LOW + 1)));  // R7

endmodule

// File: tb/sim_pid_duty_reg.sv
module sim_pid_duty_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_vld = 1'b0;
  logic [9:0]  err_code = '0;
  logic [11:0] vin_code = '0;
  logic        duty_vld;
  logic [8:0]  duty;

  int total = 0, bad = 0;
  int m_integ = 0, m_prev = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pid_duty_reg u0 (.clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .err_code(err_code),
                   .vin_code(vin_code), .duty_vld(duty_vld), .duty(duty));

  function automatic int clampd(int v);
    return (v < 0) ? 0 : (v > 511) ? 511 : v;
  endfunction

  function automatic int kp_of(int vin, int e);
    int k;
    k = (vin < 2700) ? 6 : (vin < 3300) ? 5 : 4;   // R6
    if (e >= 64) k = k + 1;                        // R7
    return k;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic fresh();
    @(negedge clk);
    rst_n = 1'b0;
    sample_vld = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 duty in reset", duty, 0);
    chk("R1 vld in reset", duty_vld, 0);
    sample_vld = 1'b0;
    rst_n = 1'b1;
    m_integ = 0;
    m_prev = 0;
  endtask

  task automatic step(int code, int vin, string tag);
    int e, integ, u, held;
    e = 512 - code;                                // R2
    integ = clampd(m_integ + (e >>> 1));           // R4
    u = clampd(kp_of(vin, e) * e + integ + 4 * (e - m_prev));  // R5 R8
    m_integ = integ;
    m_prev = e;
    @(negedge clk);
    err_code = 10'(code);
    vin_code = 12'(vin);
    sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
    err_code = 10'($urandom);
    vin_code = 12'($urandom);
    chk({tag, " vld R3"}, duty_vld, 1);
    chk({tag, " duty"}, duty, u);
    held = duty;
    @(negedge clk);
    err_code = 10'($urandom);
    vin_code = 12'($urandom);
    chk("R3 vld drops", duty_vld, 0);
    chk("R9 duty held", duty, held);
  endtask

  initial begin
    void'($urandom(32'h5eed1));
    fresh();
    step(512, 1000, "R2 zero error");
    step(511, 1000, "R4 neg-one shift");
    step(512, 1000, "R5 derivative back");
    fresh();
    step(448, 1000, "R7 err64 boost");
    step(448, 1000, "R7 err64 steady");
    fresh();
    step(449, 1000, "R7 err63 no boost");
    step(449, 1000, "R7 err63 steady");
    fresh();
    step(500, 2699, "R6 band low edge");
    step(500, 2700, "R6 band mid edge");
    step(500, 3299, "R6 band mid top");
    step(500, 3300, "R6 band high edge");
    step(500, 4095, "R6 band max");
    fresh();
    step(0, 1000, "R8 high sat");
    step(0, 1000, "R4 integ clamp");
    step(1023, 1000, "R8 low sat");
    step(1023, 4000, "R4 integ floor");
    fresh();
    for (int i = 0; i < 400; i++) begin
      int code;
      if (i % 8 == 0) code = int'($urandom_range(1023, 0));
      else code = 512 + int'($urandom_range(80, 0)) - 40;
      step(code, int'($urandom_range(4095, 0)), "R8 random");
      if (i % 5 == 0) begin
        @(negedge clk);
        err_code = 10'($urandom);
        vin_code = 12'($urandom);
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule